// File: doc/BRIEF.md
# Debug Boot Control Register

This block sits inside a test-access-port based debug unit and decides how the processor comes out of a reset. A probe loads a "debug boot" instruction into the instruction register. That sets a boot indication, which is held across any number of processor resets. While the processor is held in reset, three control bits (break, trap-select and probe-enable) all take the value of the boot indication. When the reset is released with the break bit set, the block raises a one-cycle debug request. The trap-select bit steers the exception vector to 0xFF200200 in probe memory. The probe-enable bit makes every processor fetch from probe memory stall until the probe completes it.

The control is built around a five-state machine:
- `S_RUN`: normal execution.
- `S_HOLD`: the processor is in reset.
- `S_DBG_REQ`: a one-cycle debug request.
- `S_DBG_MODE`: the processor runs the debug handler from probe memory.
- `S_PEND`: a processor access waits on the probe.

The transitions are:
- `hold_enter`: any state goes to `S_HOLD` while `cpu_rst` is high.
- `boot_debug`: `S_HOLD` goes to `S_DBG_REQ` when the reset drops with the break bit set.
- `boot_normal`: `S_HOLD` goes to `S_RUN` when the reset drops with the break bit clear.
- `req_done`: `S_DBG_REQ` goes to `S_DBG_MODE`.
- `fetch_wait`: `S_DBG_MODE` goes to `S_PEND` on a fetch while probe-enable is set.
- `probe_ack`: `S_PEND` goes back to `S_DBG_MODE` on `probe_done`.

A "normal boot" instruction clears the indication, and so does a TAP reset. Once the indication is clear, the next processor reset starts at the normal reset vector 0xBFC00000 and raises no debug request.

Top module: `dbg_boot_ctl`

## Requirements
- R1: A cycle with `ir_valid` high and `ir_code` = 5'h0C sets the boot indication. A cycle with `ir_valid` high and `ir_code` = 5'h0D clears it. Any other code, or `ir_valid` low, leaves it unchanged.
- R2: `tap_rst` high clears the boot indication, and it wins over an instruction in the same cycle. `cpu_rst` never changes the boot indication.
- R3: In every cycle in which `cpu_rst` is sampled high, the break, trap-select and probe-enable bits all load the current boot indication. The state goes to `S_HOLD`, which also drops any pending access.
- R4: `dbg_req` is high for exactly one cycle, the first cycle after `cpu_rst` is sampled low following `S_HOLD`, and only if the break bit was loaded with 1. The break bit then clears.
- R5: `vec_addr` is 0xFF200200 while the trap-select bit is 1, and 0xBFC00000 otherwise.
- R6: In `S_DBG_MODE` with probe-enable set, `fetch_req` raises `fetch_stall` in the same cycle. `acc_pend` goes to 1 from the next cycle, and `fetch_stall` stays high while `acc_pend` is 1.
- R7: `probe_done` sampled while `acc_pend` is 1 drops both `acc_pend` and `fetch_stall` from the next cycle.
- R8: After a processor reset with the boot indication clear, `dbg_req` stays low, `vec_addr` is the normal vector, and `fetch_req` never raises `fetch_stall` or `acc_pend`.
- R9: While `por_n` is sampled low, the boot indication and all three bits clear and the state returns to `S_RUN`. As a result `dbg_req`, `acc_pend` and `fetch_stall` are 0 and `vec_addr` is 0xBFC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| tap_rst | input | 1 | Test-access-port logic reset, active high |
| cpu_rst | input | 1 | Processor reset, active high |
| ir_valid | input | 1 | Instruction register update strobe |
| ir_code | input | 5 | Decoded instruction register value |
| fetch_req | input | 1 | Processor fetch from probe memory |
| probe_done | input | 1 | Probe writes 0 to the pending flag |
| dbg_req | output | 1 | Debug exception request |
| vec_addr | output | 32 | Exception vector address |
| acc_pend | output | 1 | Processor access pending on the probe |
| fetch_stall | output | 1 | Stall for the processor fetch |

## Verification
Instructions, resets and probe strobes take effect at the next rising edge. `dbg_req` and `acc_pend` are therefore due one cycle after the sampled cause. `vec_addr` follows the bits loaded at that edge. `fetch_stall` is due in the same cycle as `fetch_req`. The bench drives its inputs at the falling edge and compares all outputs 1 ns later against a behavioural model. That model advances only at the rising edge, using the values that were driven, so every registered result is checked exactly one cycle after its cause and the combinational stall in the cycle of its cause.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        S_RUN      = 3'd0,
        S_HOLD     = 3'd1,
        S_DBG_REQ  = 3'd2,
        S_DBG_MODE = 3'd3,
        S_PEND     = 3'd4
    } dbc_state_e;

    localparam int NUM_CTL = 3;
    localparam int BIT_BRK = 0;
    localparam int BIT_TRP = 1;
    localparam int BIT_PEN = 2;

endpackage

// File: rtl/dbc_boot_latch.sv
module dbc_boot_latch #(
    parameter int          IR_W      = 5,
    parameter logic [IR_W-1:0] BOOT_CODE = 5'h0C,
    parameter logic [IR_W-1:0] NORM_CODE = 5'h0D
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            tap_rst,
    input  logic            ir_valid,
    input  logic [IR_W-1:0] ir_code,
    output logic            boot_o
);

    logic boot_q;
    logic hit_boot;
    logic hit_norm;

    always_comb begin
        hit_boot = ir_valid && (ir_code == BOOT_CODE);
        hit_norm = ir_valid && (ir_code == NORM_CODE);
    end

    always_ff @(posedge clk) begin
        if (!por_n || tap_rst) begin
            boot_q <= 1'b0;
        end else if (hit_boot) begin
            boot_q <= 1'b1;
        end else if (hit_norm) begin
            boot_q <= 1'b0;
        end
    end

    assign boot_o = boot_q;

    // R1
    boot_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!tap_rst && !ir_valid) |=> (boot_q == $past(boot_q)));

    // R2
    tap_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        tap_rst |=> !boot_q);

endmodule

// File: rtl/dbc_ctl_bits.sv
module dbc_ctl_bits
    import dbc_pkg::*;
#(
    parameter logic [NUM_CTL-1:0] CLR_MASK = 3'b001
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               cpu_rst,
    input  logic               boot_i,
    input  logic               brk_clr,
    output logic [NUM_CTL-1:0] bits_o
);

    logic [NUM_CTL-1:0] bits_q;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_bit
        if (CLR_MASK[g]) begin : g_clr
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    bits_q[g] <= 1'b0;
                end else if (cpu_rst) begin
                    bits_q[g] <= boot_i;
                end else if (brk_clr) begin
                    bits_q[g] <= 1'b0;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    bits_q[g] <= 1'b0;
                end else if (cpu_rst) begin
                    bits_q[g] <= boot_i;
                end
            end
        end
    end

    assign bits_o = bits_q;

    // R3
    rst_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst |=> ((bits_q[BIT_BRK] == $past(boot_i)) &&
                     (bits_q[BIT_TRP] == $past(boot_i)) &&
                     (bits_q[BIT_PEN] == $past(boot_i))));

endmodule

// File: rtl/dbc_fsm.sv
module dbc_fsm
    import dbc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic cpu_rst,
    input  logic brk_i,
    input  logic pen_i,
    input  logic fetch_req,
    input  logic probe_done,
    output logic dbg_req,
    output logic acc_pend,
    output logic fetch_stall,
    output logic brk_clr
);

    dbc_state_e state_q;
    dbc_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (cpu_rst) begin
            state_d = S_HOLD;
        end else begin
            unique case (state_q)
                S_RUN:      state_d = S_RUN;
                S_HOLD:     state_d = brk_i ? S_DBG_REQ : S_RUN;
                S_DBG_REQ:  state_d = S_DBG_MODE;
                S_DBG_MODE: state_d = (fetch_req && pen_i) ? S_PEND : S_DBG_MODE;
                S_PEND:     state_d = probe_done ? S_DBG_MODE : S_PEND;
                default:    state_d = S_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= S_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dbg_req     = 1'b0;
        acc_pend    = 1'b0;
        fetch_stall = 1'b0;
        brk_clr     = 1'b0;
        unique case (state_q)
            S_RUN, S_HOLD: ;
            S_DBG_REQ: begin
                dbg_req = 1'b1;
                brk_clr = 1'b1;
            end
            S_DBG_MODE: fetch_stall = fetch_req && pen_i;
            S_PEND: begin
                acc_pend    = 1'b1;
                fetch_stall = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        dbg_req |=> !dbg_req);

    // R6
    pend_stall_chk: assert property (@(posedge clk) disable iff (!por_n)
        acc_pend |-> fetch_stall);

    // R7
    probe_rel_chk: assert property (@(posedge clk) disable iff (!por_n)
        (acc_pend && probe_done) |=> !acc_pend);

endmodule

// File: rtl/dbg_boot_ctl.sv
module dbg_boot_ctl
    import dbc_pkg::*;
#(
    parameter int              IR_W      = 5,
    parameter logic [IR_W-1:0] BOOT_CODE = 5'h0C,
    parameter logic [IR_W-1:0] NORM_CODE = 5'h0D,
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] DBG_VEC = 32'hFF20_0200,
    parameter logic [ADDR_W-1:0] RST_VEC = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tap_rst,
    input  logic              cpu_rst,
    input  logic              ir_valid,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              fetch_req,
    input  logic              probe_done,
    output logic              dbg_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              acc_pend,
    output logic              fetch_stall
);

    logic               boot_ind;
    logic               brk_clr;
    logic [NUM_CTL-1:0] ctl;

    dbc_boot_latch #(
        .IR_W      (IR_W),
        .BOOT_CODE (BOOT_CODE),
        .NORM_CODE (NORM_CODE)
    ) u_latch (
        .clk      (clk),
        .por_n    (por_n),
        .tap_rst  (tap_rst),
        .ir_valid (ir_valid),
        .ir_code  (ir_code),
        .boot_o   (boot_ind)
    );

    dbc_ctl_bits #(
        .CLR_MASK (3'b001)
    ) u_bits (
        .clk     (clk),
        .por_n   (por_n),
        .cpu_rst (cpu_rst),
        .boot_i  (boot_ind),
        .brk_clr (brk_clr),
        .bits_o  (ctl)
    );

    dbc_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .cpu_rst     (cpu_rst),
        .brk_i       (ctl[BIT_BRK]),
        .pen_i       (ctl[BIT_PEN]),
        .fetch_req   (fetch_req),
        .probe_done  (probe_done),
        .dbg_req     (dbg_req),
        .acc_pend    (acc_pend),
        .fetch_stall (fetch_stall),
        .brk_clr     (brk_clr)
    );

    assign vec_addr = ctl[BIT_TRP] ? DBG_VEC : RST_VEC;

    // R2
    cpu_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_rst && !tap_rst && !ir_valid) |=> (boot_ind == $past(boot_ind)));

    // R8
    norm_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_rst && !boot_ind) |=> (!dbg_req && (vec_addr == RST_VEC)));

endmodule

// File: tb/test_dbg_boot_ctl.sv
`timescale 1ns/1ps
module test_dbg_boot_ctl;

    localparam logic [31:0] DVEC = 32'hFF20_0200;
    localparam logic [31:0] NVEC = 32'hBFC0_0000;
    localparam logic [4:0]  C_BOOT = 5'h0C;
    localparam logic [4:0]  C_NORM = 5'h0D;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, tap_rst = 1'b0, cpu_rst = 1'b0;
    logic        ir_valid = 1'b0, fetch_req = 1'b0, probe_done = 1'b0;
    logic [4:0]  ir_code = 5'd0;
    logic        dbg_req, acc_pend, fetch_stall;
    logic [31:0] vec_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state: 0 run, 1 hold, 2 req, 3 dbg mode, 4 pending
    int   m_st = 0;
    logic m_boot = 0, m_brk = 0, m_trp = 0, m_pen = 0;

    always #2.5 clk = ~clk;

    dbg_boot_ctl i_dbg_boot_ctl (
        .clk(clk), .por_n(por_n), .tap_rst(tap_rst), .cpu_rst(cpu_rst),
        .ir_valid(ir_valid), .ir_code(ir_code), .fetch_req(fetch_req),
        .probe_done(probe_done), .dbg_req(dbg_req), .vec_addr(vec_addr),
        .acc_pend(acc_pend), .fetch_stall(fetch_stall)
    );

    function automatic logic [31:0] exp_vec();
        return m_trp ? DVEC : NVEC;
    endfunction

    function automatic logic exp_stall();
        return (m_st == 4) || (m_st == 3 && fetch_req && m_pen);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic nb;
        int   ns;
        if (!por_n) begin
            m_boot = 0; m_brk = 0; m_trp = 0; m_pen = 0; m_st = 0;
        end else begin
            nb = m_boot;
            if (tap_rst) nb = 0;
            else if (ir_valid && ir_code == C_BOOT) nb = 1;
            else if (ir_valid && ir_code == C_NORM) nb = 0;
            ns = m_st;
            if (cpu_rst) ns = 1;
            else if (m_st == 1) ns = m_brk ? 2 : 0;
            else if (m_st == 2) ns = 3;
            else if (m_st == 3 && fetch_req && m_pen) ns = 4;
            else if (m_st == 4 && probe_done) ns = 3;
            if (cpu_rst) begin
                m_brk = m_boot; m_trp = m_boot; m_pen = m_boot;
            end else if (m_st == 2) begin
                m_brk = 0;
            end
            m_st = ns;
            m_boot = nb;
        end
    endtask

    // apply inputs at falling edge, compare, advance one clock
    task automatic step(input logic tr, input logic cr, input logic iv,
                        input logic [4:0] ic, input logic fr, input logic pd);
        tap_rst = tr; cpu_rst = cr; ir_valid = iv; ir_code = ic;
        fetch_req = fr; probe_done = pd;
        #1;
        chk("R4 dbg_req", {31'd0, dbg_req}, {31'd0, m_st == 2});
        chk("R5 vec_addr", vec_addr, exp_vec());
        chk("R6 acc_pend", {31'd0, acc_pend}, {31'd0, m_st == 4});
        chk("R7 fetch_stall", {31'd0, fetch_stall}, {31'd0, exp_stall()});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 5'd0, 0, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        por_n = 1'b0;
        repeat (3) @(posedge clk);
        model_edge();
        @(negedge clk);
        // R9 reset state
        chk("R9 dbg_req", {31'd0, dbg_req}, 32'd0);
        chk("R9 acc_pend", {31'd0, acc_pend}, 32'd0);
        chk("R9 fetch_stall", {31'd0, fetch_stall}, 32'd0);
        chk("R9 vec_addr", vec_addr, NVEC);
        por_n = 1'b1;
        idle(2);

        // R8: no boot, reset, fetch ignored
        step(0, 1, 0, 5'd0, 0, 0);
        step(0, 0, 0, 5'd0, 0, 0);
        step(0, 0, 0, 5'd0, 1, 0);
        chk("R8 no stall", {31'd0, fetch_stall}, 32'd0);
        chk("R8 no req", {31'd0, dbg_req}, 32'd0);

        // R1: boot instruction then processor reset -> debug request
        step(0, 0, 1, C_BOOT, 0, 0);
        step(0, 1, 0, 5'd0, 0, 0);
        chk("R3 vec during reset", vec_addr, DVEC);
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R1 dbg_req after boot", {31'd0, dbg_req}, 32'd1);
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R4 single pulse", {31'd0, dbg_req}, 32'd0);
        // R6 fetch stalls, R7 probe releases
        step(0, 0, 0, 5'd0, 1, 0);
        chk("R6 pending", {31'd0, acc_pend}, 32'd1);
        idle(3);
        chk("R6 still pending", {31'd0, fetch_stall}, 32'd1);
        step(0, 0, 0, 5'd0, 0, 1);
        chk("R7 released", {31'd0, acc_pend}, 32'd0);

        // R2: second processor reset keeps the indication
        step(0, 1, 0, 5'd0, 0, 0);
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R2 boot survives cpu reset", {31'd0, dbg_req}, 32'd1);
        // R2: TAP reset clears, even with a boot instruction alongside
        step(1, 0, 1, C_BOOT, 0, 0);
        step(0, 1, 0, 5'd0, 0, 0);
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R2 tap reset clears", {31'd0, dbg_req}, 32'd0);
        chk("R2 normal vector", vec_addr, NVEC);
        // R1: normal instruction clears, other codes ignored
        step(0, 0, 1, C_BOOT, 0, 0);
        step(0, 0, 1, 5'h05, 0, 0);
        step(0, 0, 1, C_NORM, 0, 0);
        step(0, 0, 1, 5'h1F, 0, 0);
        step(0, 1, 0, 5'd0, 0, 0);
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R1 normal code clears", {31'd0, dbg_req}, 32'd0);
        // R3: processor reset drops a pending access
        step(0, 0, 1, C_BOOT, 0, 0);
        step(0, 1, 0, 5'd0, 0, 0);
        idle(2);
        step(0, 0, 0, 5'd0, 1, 0);
        step(0, 1, 0, 5'd0, 0, 0);
        chk("R3 pending dropped", {31'd0, acc_pend}, 32'd0);
        idle(2);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic tr, cr, iv, fr, pd;
            logic [4:0] ic;
            int sel;
            tr = ($urandom % 60) == 0;
            cr = ($urandom % 25) == 0;
            iv = ($urandom % 8) == 0;
            sel = $urandom % 3;
            ic = (sel == 0) ? C_BOOT : (sel == 1) ? C_NORM : 5'($urandom);
            fr = ($urandom % 3) == 0;
            pd = ($urandom % 4) == 0;
            step(tr, cr, iv, ic, fr, pd);
        end

        // R9: power-on reset mid-run
        step(0, 0, 1, C_BOOT, 0, 0);
        step(0, 1, 0, 5'd0, 0, 0);
        por_n = 1'b0;
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R9 vec after por", vec_addr, NVEC);
        por_n = 1'b1;
        step(0, 1, 0, 5'd0, 0, 0);
        step(0, 0, 0, 5'd0, 0, 0);
        chk("R9 boot cleared", {31'd0, dbg_req}, 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule